// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Sequencer

This block sits between a synchronous request port and an asynchronous static RAM with active-low chip, output and write strobes. A client offers one request at a time. Each request is a read or a write of a single byte at a 17-bit address. The sequencer latches the request and holds the address on the memory pins for the whole cycle. It then steps through counted phases so that the memory's access time, write pulse width, data setup and address/data hold are all met in whole clock cycles. A one-cycle response ends every request. For a read, the response carries the captured byte.

The state machine has five states. IDLE is the only state that accepts work. RD_ACCESS holds chip and output enable low. RD_RECOVER releases both strobes and keeps the address. WR_PULSE holds chip and write enable low while the data is driven. WR_HOLD raises write enable and keeps chip enable low, the address and the data. The transitions are:
- IDLE→RD_ACCESS or IDLE→WR_PULSE when a request is accepted.
- RD_ACCESS→RD_RECOVER and WR_PULSE→WR_HOLD when the phase counter expires.
- RD_RECOVER→IDLE and WR_HOLD→IDLE when the recovery count expires.

Write enable is the edge that ends a write, and output enable stays high throughout every write.

A `hold_off` input keeps chip enable high. While it is high, the sequencer refuses new requests, and a cycle already started runs to its end. Phase lengths are integer parameters in clock cycles, and each must be at least 1. The write pulse lasts the larger of the pulse-width and data-setup counts.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset the memory strobes `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, `rsp_valid` is low, and `req_ready` is high.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. After that edge, `req_ready` stays low and returns high in cycle T_ACC+T_HOLD+1 for a read, or in cycle WP_LEN+T_HOLD+1 for a write. Cycle 1 is the cycle right after the accepting edge.
- R3: A read holds `mem_ce_n` low, `mem_oe_n` low and `mem_we_n` high for exactly T_ACC cycles. `mem_dq_in` is captured on the last of these cycles. The captured byte appears on `rsp_rdata` with `rsp_valid` in cycle T_ACC+1.
- R4: A write holds `mem_ce_n` and `mem_we_n` low for exactly WP_LEN = max(T_WP, T_DSU) cycles, and `mem_oe_n` stays high whenever `mem_we_n` is low.
- R5: Write data is driven (`mem_dq_oe` high) from the first cycle of the write pulse to the end of the hold phase, and it does not change while driven.
- R6: `mem_addr` does not change from the first cycle of a request until the sequencer is back in IDLE.
- R7: The data bus is released in IDLE, and `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: After a write pulse, `mem_ce_n` stays low, `mem_we_n` is high and the data stays driven for T_HOLD cycles. After a read, both enables are high for T_HOLD cycles.
- R9: Every request gives exactly one `rsp_valid` pulse of one cycle: in cycle T_ACC+1 for a read and in cycle WP_LEN+1 for a write.
- R10: While `hold_off` is high, `req_ready` is low and `mem_ce_n` cannot fall. A write already in flight still completes: its response arrives and its byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_off | input | 1 | Keeps chip enable high and refuses new requests |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte captured by the most recent read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Two functions can meet in one cycle: refusing work because of `hold_off`, and finishing a write that is already on the bus. The bench provokes this by raising `hold_off` in the first cycle of a write pulse. It then checks three things: the response still arrives in cycle WP_LEN+1, `req_ready` stays low while `hold_off` is high, and a later read returns the new byte. A second meeting point is bus release followed by a read turnaround. Writes and reads are issued back to back, and a bus monitor counts every cycle in which the controller drives the bus while output enable is low. The memory model returns a junk byte until the access count has elapsed, so a capture made one cycle early shows up as a data mismatch.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_RECOVER = 3'd2,
        ST_WR_PULSE   = 3'd3,
        ST_WR_HOLD    = 3'd4
    } seq_state_t;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_bus_pkg::*;
#(
    parameter int T_ACC  = 18,
    parameter int T_WP   = 14,
    parameter int T_DSU  = 8,
    parameter int T_HOLD = 4,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_off,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_last,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output seq_state_t       state_o,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             finish,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);
    localparam int WP_LEN = (T_WP > T_DSU) ? T_WP : T_DSU;
    localparam int RUN_W  = CNT_W + 1;

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign ready  = (state_q == ST_IDLE) && !hold_off;
    assign accept = req_valid && ready;

    // next state and phase counter loading
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    timer_load = 1'b1;
                    if (req_write) begin
                        state_d   = ST_WR_PULSE;
                        timer_val = CNT_W'(WP_LEN - 1);
                    end else begin
                        state_d   = ST_RD_ACCESS;
                        timer_val = CNT_W'(T_ACC - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (phase_last) begin
                    state_d    = ST_RD_RECOVER;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(T_HOLD - 1);
                end
            end
            ST_RD_RECOVER: begin
                if (phase_last)
                    state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (phase_last) begin
                    state_d    = ST_WR_HOLD;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(T_HOLD - 1);
                end
            end
            ST_WR_HOLD: begin
                if (phase_last)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        ce_n    = 1'b1;
        oe_n    = 1'b1;
        we_n    = 1'b1;
        dq_oe   = 1'b0;
        capture = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_ACCESS: begin
                ce_n    = 1'b0;
                oe_n    = 1'b0;
                capture = phase_last;
                finish  = phase_last;
            end
            ST_RD_RECOVER: ;
            ST_WR_PULSE: begin
                ce_n   = 1'b0;
                we_n   = 1'b0;
                dq_oe  = 1'b1;
                finish = phase_last;
            end
            ST_WR_HOLD: begin
                ce_n  = 1'b0;
                dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // run-length counters for the strobe checks
    logic [RUN_W-1:0] we_run_q, oe_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            oe_run_q <= '0;
        end else begin
            we_run_q <= we_n ? '0 : we_run_q + 1'b1;
            oe_run_q <= oe_n ? '0 : oe_run_q + 1'b1;
        end
    end

    // R7
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !oe_n));
    // R4
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n));
    // R4
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run_q == RUN_W'(WP_LEN)));
    // R3
    oe_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_run_q == RUN_W'(T_ACC)));
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 18,
    parameter int T_WP   = 14,
    parameter int T_DSU  = 8,
    parameter int T_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_off,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WP_LEN  = (T_WP > T_DSU) ? T_WP : T_DSU;
    localparam int MAX_A   = (T_ACC > WP_LEN) ? T_ACC : WP_LEN;
    localparam int MAX_LEN = (MAX_A > T_HOLD) ? MAX_A : T_HOLD;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             timer_load, phase_last;
    logic [CNT_W-1:0] timer_val;
    logic             accept, capture, finish;
    seq_state_t       state;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .last     (phase_last)
    );

    sram_seq_fsm #(
        .T_ACC (T_ACC), .T_WP (T_WP), .T_DSU (T_DSU),
        .T_HOLD(T_HOLD), .CNT_W(CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_off   (hold_off),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .phase_last (phase_last),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .state_o    (state),
        .ready      (req_ready),
        .accept     (accept),
        .capture    (capture),
        .finish     (finish),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_oe      (mem_dq_oe)
    );

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rsp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= mem_dq_in;
            rsp_q <= finish;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rsp_q;
    assign rsp_rdata  = rdata_q;

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(mem_addr));
    // R5
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
    // R9
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R10
    hold_off_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_off && mem_ce_n) |=> mem_ce_n);
endmodule

// File: tb/sram_bus_ctrl_test.sv
`timescale 1ns/1ps
module sram_bus_ctrl_test;
    localparam int ACC  = 3;
    localparam int WP   = 2;
    localparam int DSU  = 3;
    localparam int HOLD = 2;
    localparam int WPL  = (WP > DSU) ? WP : DSU;
    localparam int NADR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_off = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;

    always #2 clk = ~clk;

    sram_bus_ctrl #(.T_ACC(ACC), .T_WP(WP), .T_DSU(DSU), .T_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .hold_off(hold_off),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural memory and bus monitors, sampled mid-cycle
    logic [7:0] model [0:255];
    int acc_cnt = 0, wr_len = 0, rd_len = 0;
    int fight_err = 0, wlen_err = 0, rlen_err = 0, hold_err = 0, addr_err = 0, drv_err = 0;
    logic [16:0] wr_a;
    logic [7:0]  wr_d;
    wire reading = !mem_ce_n && !mem_oe_n && mem_we_n;

    initial for (int k = 0; k < 256; k++) model[k] = 8'h00;

    assign mem_dq_in = (reading && acc_cnt >= ACC) ? model[mem_addr[7:0]] : 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            acc_cnt <= reading ? acc_cnt + 1 : 0;
            if (mem_dq_oe && !mem_oe_n) fight_err++;
            if (reading) rd_len++;
            else if (rd_len != 0) begin
                if (rd_len != ACC) rlen_err++;
                rd_len = 0;
            end
            if (!mem_ce_n && !mem_we_n) begin
                if (!mem_oe_n || !mem_dq_oe) drv_err++;
                if (wr_len == 0) begin
                    wr_a = mem_addr;
                end else if (mem_addr != wr_a || mem_dq_out != wr_d) addr_err++;
                wr_d = mem_dq_out;
                wr_len++;
            end else if (wr_len != 0) begin
                if (wr_len != WPL) wlen_err++;
                if (mem_ce_n || !mem_dq_oe || mem_addr != wr_a || mem_dq_out != wr_d) hold_err++;
                model[wr_a[7:0]] = wr_d;
                wr_len = 0;
            end
        end
    end

    function automatic logic [16:0] adr_of(input int i);
        return 17'(i * 4099 + 7);
    endfunction
    function automatic logic [7:0] dat_of(input int i, input int salt);
        return 8'(i * 29 + 11 + salt * 53);
    endfunction

    int rsp_lat, rdy_lat, extra;
    logic [7:0] rd_byte;

    task automatic do_req(input bit w, input logic [16:0] a, input logic [7:0] d,
                          input bit raise_hold);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        guard = 0;
        while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0; req_wdata = 8'h00; req_addr = '0;
        rsp_lat = -1; rdy_lat = -1; extra = 0; rd_byte = 8'h00;
        for (int n = 1; n < 200; n++) begin
            if (raise_hold && n == 1) hold_off = 1'b1;
            if (rsp_valid) begin
                if (rsp_lat < 0) begin rsp_lat = n; rd_byte = rsp_rdata; end
                else extra++;
            end
            if (req_ready) begin rdy_lat = n; break; end
            if (raise_hold && rsp_lat > 0 && n >= rsp_lat + 6) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !rsp_valid, "R1 bus released, no response", {mem_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        // write sweep
        for (int i = 0; i < NADR; i++) begin
            do_req(1'b1, adr_of(i), dat_of(i, 0), 1'b0);
            chk(rsp_lat == WPL + 1, "R9 write response cycle", rsp_lat, WPL + 1);
            chk(extra == 0, "R9 single write response", extra, 0);
            chk(rdy_lat == WPL + HOLD + 1, "R2 write ready return", rdy_lat, WPL + HOLD + 1);
        end
        // read sweep
        for (int i = 0; i < NADR; i++) begin
            do_req(1'b0, adr_of(i), 8'h00, 1'b0);
            chk(rd_byte == dat_of(i, 0), "R3 read data", rd_byte, dat_of(i, 0));
            chk(rsp_lat == ACC + 1, "R3 read response cycle", rsp_lat, ACC + 1);
            chk(extra == 0, "R9 single read response", extra, 0);
            chk(rdy_lat == ACC + HOLD + 1, "R2 read ready return", rdy_lat, ACC + HOLD + 1);
        end
        // alternating write/read turnaround
        for (int i = 0; i < NADR; i += 3) begin
            do_req(1'b1, adr_of(i), dat_of(i, 1), 1'b0);
            do_req(1'b0, adr_of(i), 8'h00, 1'b0);
            chk(rd_byte == dat_of(i, 1), "R7 read after write turnaround", rd_byte, dat_of(i, 1));
        end

        // R10 hold_off while idle: request offered but refused
        @(negedge clk);
        hold_off = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = adr_of(1); req_wdata = 8'hFF;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            chk(!req_ready && mem_ce_n && !rsp_valid, "R10 refused while held off",
                {req_ready, mem_ce_n, rsp_valid}, 2);
        end
        req_valid = 1'b0;
        @(negedge clk);
        hold_off = 1'b0;
        do_req(1'b0, adr_of(1), 8'h00, 1'b0);
        chk(rd_byte == dat_of(1, 0), "R10 refused write left memory intact", rd_byte, dat_of(1, 0));

        // R10 hold_off raised during a write pulse
        do_req(1'b1, adr_of(2), 8'h5A, 1'b1);
        chk(rsp_lat == WPL + 1, "R10 in-flight write still responds", rsp_lat, WPL + 1);
        chk(rdy_lat == -1, "R10 ready stays low while held off", rdy_lat, -1);
        chk(mem_ce_n, "R10 chip enable high after completion", mem_ce_n, 1);
        hold_off = 1'b0;
        do_req(1'b0, adr_of(2), 8'h00, 1'b0);
        chk(rd_byte == 8'h5A, "R10 in-flight write stored", rd_byte, 8'h5A);

        // monitor totals
        chk(fight_err == 0, "R7 bus driven while output enabled", fight_err, 0);
        chk(wlen_err == 0, "R4 write pulse length", wlen_err, 0);
        chk(drv_err == 0, "R4 R5 output enable high and data driven in pulse", drv_err, 0);
        chk(rlen_err == 0, "R3 read strobe length", rlen_err, 0);
        chk(hold_err == 0, "R8 write hold phase", hold_err, 0);
        chk(addr_err == 0, "R6 address/data stable in pulse", addr_err, 0);
        @(negedge clk);
        chk(!mem_dq_oe, "R8 bus released after recovery", mem_dq_oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule